// File: doc/BRIEF.md
# SPI Register-Access Request Engine

This block is the peripheral-side protocol layer of a byte-wide SPI link. A bit-level shifter, which is outside this block, hands it each received byte, the chip-select level and a pulse each time it loads the next byte to transmit. The engine collects a fixed four-byte request frame and checks its CRC-8 trailer. It then decodes the request and performs a register read, a single-byte write or a two-phase long write through a simple register-file port. The reply frame it returns carries a result code and its own CRC-8. Whenever it has nothing meaningful to send, it returns 0xFF.

The register file supplies two lookups for the current register number: whether that number exists (`reg_ok`) and the longest transfer it accepts (`reg_max_len`). Read data arrives one cycle after each read strobe. Written bytes are staged in an internal buffer and reach the register port only after their frame's CRC has matched. Raising chip select abandons whatever is in progress.

The controller is a single state machine with these states:
- `S_HDR`: collects header bytes.
- `S_CHECK`: decodes the request for one cycle.
- `S_FETCH`: reads the requested bytes into the buffer.
- `S_COMMIT`: writes buffered bytes to the register port.
- `S_RESP`: sends the reply.
- `S_DRAIN`: discards the byte that overlaps the last reply byte.
- `S_PAYLOAD`: collects long-write data.
- `S_PAYCHK`: judges the payload CRC.
- `S_HOLD`: idles until chip select rises.

Its transitions are:
- `S_HDR` goes to `S_CHECK` on the fourth byte.
- `S_CHECK` goes to `S_RESP` on any error or on an accepted long-write start, to `S_FETCH` on a read, and to `S_COMMIT` on a short write.
- `S_FETCH` goes to `S_RESP` once every byte is captured.
- `S_COMMIT` goes to `S_RESP` after the last byte is written.
- `S_RESP` goes to `S_DRAIN` after its last byte if a long write is armed, and otherwise to `S_HOLD`.
- `S_DRAIN` goes to `S_PAYLOAD` on the next received byte.
- `S_PAYLOAD` goes to `S_PAYCHK` on the CRC byte.
- `S_PAYCHK` goes to `S_COMMIT` if the CRC matches, and otherwise to `S_RESP`.
- Any state goes to `S_HDR` whenever `cs_n` is high.

Top module: `spi_req_engine`

## Requirements
- R1: The first frame after `cs_n` falls is four bytes: type, register number, argument (length or data), then CRC-8 of the first three. The CRC-8 uses polynomial 0x07, starts at 0x00, is not reflected and has no final XOR.
- R2: Type 0xC0 and type 0xC1 both mean read, 0xC2 means short write and 0xC3 means long-write start. Every other type is answered with 0xA2.
- R3: Result codes are 0xA0 OK, 0xA1 CRC error, 0xA2 bad type, 0xA3 bad register and 0xA4 bad length. When several errors apply, the first in that list (after OK) wins.
- R4: Every byte loaded for transmit outside a reply is 0xFF. This covers request reception, turnaround, payload reception and the idle time after a reply.
- R5: A short reply is the result code followed by its CRC-8. The pairs are A0/69, A1/6E, A2/67, A3/60 and A4/75.
- R6: A successful read reply is 0xA0, then the requested bytes in offset order, then the CRC-8 of every earlier reply byte. A failed read sends the short reply only.
- R7: A read or long-write start whose length is 0, above `reg_max_len` or above MAX_PAYLOAD gets 0xA4 and causes no register access.
- R8: After a long-write start answered 0xA0, the engine ignores the byte received alongside the last reply byte. The next length+1 bytes are then the payload and its CRC, and they are answered with a short reply. A start answered with any other code arms nothing, and later bytes are ignored until `cs_n` rises.
- R9: `cs_n` high returns the engine to header collection within one cycle and stops any register access, so an unfinished frame commits nothing.
- R10: Register writes occur only after a frame's CRC has matched. A mismatch yields 0xA1 and no write strobe.
- R11: Reads strobe `reg_rd_en` with offsets 0 to len-1 and take `reg_rdata` one cycle after each strobe. Writes strobe `reg_wr_en` once per byte with offsets 0 to len-1. The two strobes never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip-select level, active low |
| rx_valid | input | 1 | One-cycle pulse: `rx_byte` holds a completed byte |
| rx_byte | input | 8 | Byte received from the host |
| tx_load | input | 1 | One-cycle pulse: the shifter takes `tx_byte` now |
| tx_byte | output | 8 | Next byte to transmit |
| reg_addr | output | 8 | Register number of the current request |
| reg_offset | output | $clog2(MAX_PAYLOAD) | Byte offset within the register |
| reg_rd_en | output | 1 | Read strobe |
| reg_rdata | input | 8 | Read data, valid one cycle after the strobe |
| reg_wr_en | output | 1 | Write strobe |
| reg_wdata | output | 8 | Write data |
| reg_ok | input | 1 | `reg_addr` names an existing register |
| reg_max_len | input | 8 | Largest transfer allowed for `reg_addr` |

## Verification
The bench goes after these corner cases:
- **Error priority.** A frame carrying both a wrong type and a wrong CRC must get 0xA1. A design that checked the type first would answer 0xA2.
- **Length limits.** Lengths of zero, over the register limit and over the buffer depth must each get 0xA4 with no read strobe. A design that fetched first would leak side-effecting reads.
- **Long-write payload.** A payload with a corrupt CRC, and a payload cut off by `cs_n`, must leave the register contents and the write-strobe count unchanged. A design that streamed payload bytes straight to the register port would corrupt them.
- **Rejected long-write start.** After a rejected start, further bytes must only ever return 0xFF. A design that armed the payload phase anyway would treat them as data.
- **Drain byte.** A read-back after a long write checks that the overlapping drain byte was discarded. Any off-by-one there would shift every payload byte.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [3:0] {
        S_HDR,
        S_CHECK,
        S_FETCH,
        S_COMMIT,
        S_RESP,
        S_DRAIN,
        S_PAYLOAD,
        S_PAYCHK,
        S_HOLD
    } eng_state_e;

    typedef enum logic [1:0] {
        K_READ,
        K_SWRITE,
        K_LSTART,
        K_NONE
    } req_kind_e;

    localparam logic [7:0] TYP_READ_A = 8'hC0;
    localparam logic [7:0] TYP_READ_B = 8'hC1;
    localparam logic [7:0] TYP_SWRITE = 8'hC2;
    localparam logic [7:0] TYP_LSTART = 8'hC3;

    localparam logic [7:0] RES_OK      = 8'hA0;
    localparam logic [7:0] RES_CRC     = 8'hA1;
    localparam logic [7:0] RES_TYPE    = 8'hA2;
    localparam logic [7:0] RES_REG     = 8'hA3;
    localparam logic [7:0] RES_LEN     = 8'hA4;

    localparam logic [7:0] FILL_BYTE   = 8'hFF;

endpackage

// File: rtl/eng_crc8.sv
module eng_crc8 #(
    parameter logic [7:0] POLY = 8'h07
) (
    input  logic [7:0] crc_in,
    input  logic [7:0] data_in,
    output logic [7:0] crc_out
);
    logic [7:0] stage [0:8];

    assign stage[0] = crc_in ^ data_in;

    genvar b;
    generate
        for (b = 0; b < 8; b++) begin : g_bit
            assign stage[b+1] = stage[b][7] ? ({stage[b][6:0], 1'b0} ^ POLY)
                                            : {stage[b][6:0], 1'b0};
        end
    endgenerate

    assign crc_out = stage[8];
endmodule

// File: rtl/eng_byte_buf.sv
module eng_byte_buf #(
    parameter int DEPTH = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/eng_decode.sv
module eng_decode
    import spi_eng_pkg::*;
#(
    parameter int MAX_PAYLOAD = 16
) (
    input  logic [7:0] req_type,
    input  logic [7:0] req_arg,
    input  logic       crc_ok,
    input  logic       reg_ok,
    input  logic [7:0] reg_max_len,
    output req_kind_e  kind,
    output logic [7:0] result
);
    localparam logic [7:0] MAX_B = 8'(MAX_PAYLOAD);

    logic len_bad;

    always_comb begin
        unique case (req_type)
            TYP_READ_A, TYP_READ_B: kind = K_READ;
            TYP_SWRITE:             kind = K_SWRITE;
            TYP_LSTART:             kind = K_LSTART;
            default:                kind = K_NONE;
        endcase
    end

    assign len_bad = (kind == K_READ || kind == K_LSTART) &&
                     (req_arg == 8'd0 || req_arg > reg_max_len || req_arg > MAX_B);

    always_comb begin
        if (!crc_ok) begin
            result = RES_CRC;
        end else if (kind == K_NONE) begin
            result = RES_TYPE;
        end else if (!reg_ok) begin
            result = RES_REG;
        end else if (len_bad) begin
            result = RES_LEN;
        end else begin
            result = RES_OK;
        end
    end
endmodule

// File: rtl/spi_req_engine.sv
module spi_req_engine
    import spi_eng_pkg::*;
#(
    parameter int         MAX_PAYLOAD = 16,
    parameter logic [7:0] CRC_POLY    = 8'h07,
    localparam int        OFS_W       = $clog2(MAX_PAYLOAD),
    localparam int        IDX_W       = $clog2(MAX_PAYLOAD + 3)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             tx_load,
    output logic [7:0]       tx_byte,
    output logic [7:0]       reg_addr,
    output logic [OFS_W-1:0] reg_offset,
    output logic             reg_rd_en,
    input  logic [7:0]       reg_rdata,
    output logic             reg_wr_en,
    output logic [7:0]       reg_wdata,
    input  logic             reg_ok,
    input  logic [7:0]       reg_max_len
);
    eng_state_e        state, nxt;

    logic [1:0]        hdr_cnt;
    logic [7:0]        hdr_type, hdr_reg, hdr_arg;
    logic              crc_ok;
    logic [7:0]        rx_crc, rx_crc_nxt;
    logic [7:0]        rsp_crc, rsp_crc_nxt;
    logic [7:0]        result;
    logic [IDX_W-1:0]  cur_len;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  rsp_total;
    logic              armed;

    req_kind_e         dec_kind;
    logic [7:0]        dec_result;

    logic              buf_we;
    logic [OFS_W-1:0]  buf_waddr, buf_raddr;
    logic [7:0]        buf_wdata, buf_rdata;

    // CRC over received bytes (header, then payload)
    eng_crc8 #(.POLY(CRC_POLY)) u_rx_crc (
        .crc_in  (rx_crc),
        .data_in (rx_byte),
        .crc_out (rx_crc_nxt)
    );

    // CRC over transmitted reply bytes
    eng_crc8 #(.POLY(CRC_POLY)) u_tx_crc (
        .crc_in  (rsp_crc),
        .data_in (tx_byte),
        .crc_out (rsp_crc_nxt)
    );

    eng_decode #(.MAX_PAYLOAD(MAX_PAYLOAD)) u_decode (
        .req_type    (hdr_type),
        .req_arg     (hdr_arg),
        .crc_ok      (crc_ok),
        .reg_ok      (reg_ok),
        .reg_max_len (reg_max_len),
        .kind        (dec_kind),
        .result      (dec_result)
    );

    eng_byte_buf #(.DEPTH(MAX_PAYLOAD)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (buf_wdata),
        .raddr (buf_raddr),
        .rdata (buf_rdata)
    );

    // Next-state logic
    always_comb begin
        nxt = state;
        if (cs_n) begin
            nxt = S_HDR;
        end else begin
            unique case (state)
                S_HDR: begin
                    if (rx_valid && hdr_cnt == 2'd3) nxt = S_CHECK;
                end
                S_CHECK: begin
                    if (dec_result != RES_OK)      nxt = S_RESP;
                    else if (dec_kind == K_READ)   nxt = S_FETCH;
                    else if (dec_kind == K_SWRITE) nxt = S_COMMIT;
                    else                           nxt = S_RESP;
                end
                S_FETCH: begin
                    if (idx == cur_len) nxt = S_RESP;
                end
                S_COMMIT: begin
                    if (idx == cur_len - 1'b1) nxt = S_RESP;
                end
                S_RESP: begin
                    if (tx_load && idx == rsp_total - 1'b1) begin
                        nxt = armed ? S_DRAIN : S_HOLD;
                    end
                end
                S_DRAIN: begin
                    if (rx_valid) nxt = S_PAYLOAD;
                end
                S_PAYLOAD: begin
                    if (rx_valid && idx == cur_len) nxt = S_PAYCHK;
                end
                S_PAYCHK: begin
                    nxt = crc_ok ? S_COMMIT : S_RESP;
                end
                S_HOLD: begin
                    nxt = S_HOLD;
                end
                default: nxt = S_HDR;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_HDR;
        end else begin
            state <= nxt;
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_cnt   <= '0;
            hdr_type  <= '0;
            hdr_reg   <= '0;
            hdr_arg   <= '0;
            crc_ok    <= 1'b0;
            rx_crc    <= '0;
            rsp_crc   <= '0;
            result    <= RES_OK;
            cur_len   <= '0;
            idx       <= '0;
            rsp_total <= IDX_W'(2);
            armed     <= 1'b0;
        end else if (cs_n) begin
            hdr_cnt   <= '0;
            rx_crc    <= '0;
            rsp_crc   <= '0;
            idx       <= '0;
            armed     <= 1'b0;
        end else begin
            if (state != S_RESP) begin
                rsp_crc <= '0;
            end
            unique case (state)
                S_HDR: begin
                    if (rx_valid) begin
                        unique case (hdr_cnt)
                            2'd0: hdr_type <= rx_byte;
                            2'd1: hdr_reg  <= rx_byte;
                            2'd2: hdr_arg  <= rx_byte;
                            default: crc_ok <= (rx_byte == rx_crc);
                        endcase
                        if (hdr_cnt != 2'd3) begin
                            rx_crc <= rx_crc_nxt;
                        end
                        hdr_cnt <= hdr_cnt + 1'b1;
                    end
                end
                S_CHECK: begin
                    result    <= dec_result;
                    rsp_total <= IDX_W'(2);
                    idx       <= '0;
                    cur_len   <= (dec_kind == K_SWRITE) ? IDX_W'(1) : IDX_W'(hdr_arg);
                    armed     <= (dec_kind == K_LSTART) && (dec_result == RES_OK);
                end
                S_FETCH: begin
                    if (idx == cur_len) begin
                        idx       <= '0;
                        rsp_total <= cur_len + IDX_W'(2);
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                S_COMMIT: begin
                    idx <= (idx == cur_len - 1'b1) ? '0 : idx + 1'b1;
                end
                S_RESP: begin
                    if (tx_load) begin
                        rsp_crc <= rsp_crc_nxt;
                        idx     <= idx + 1'b1;
                    end
                end
                S_DRAIN: begin
                    rx_crc <= '0;
                    idx    <= '0;
                end
                S_PAYLOAD: begin
                    if (rx_valid) begin
                        if (idx == cur_len) begin
                            crc_ok <= (rx_byte == rx_crc);
                        end else begin
                            rx_crc <= rx_crc_nxt;
                            idx    <= idx + 1'b1;
                        end
                    end
                end
                S_PAYCHK: begin
                    armed     <= 1'b0;
                    idx       <= '0;
                    rsp_total <= IDX_W'(2);
                    result    <= crc_ok ? RES_OK : RES_CRC;
                end
                S_HOLD: begin
                    idx <= '0;
                end
                default: begin
                    idx <= '0;
                end
            endcase
        end
    end

    // Outputs and buffer port steering
    always_comb begin
        tx_byte    = FILL_BYTE;
        reg_addr   = hdr_reg;
        reg_offset = OFS_W'(idx);
        reg_rd_en  = 1'b0;
        reg_wr_en  = 1'b0;
        reg_wdata  = buf_rdata;
        buf_we     = 1'b0;
        buf_waddr  = OFS_W'(idx);
        buf_wdata  = rx_byte;
        buf_raddr  = OFS_W'(idx);
        unique case (state)
            S_CHECK: begin
                buf_we    = (dec_kind == K_SWRITE) && (dec_result == RES_OK);
                buf_waddr = '0;
                buf_wdata = hdr_arg;
            end
            S_FETCH: begin
                reg_rd_en = !cs_n && (idx != cur_len);
                buf_we    = (idx != '0);
                buf_waddr = OFS_W'(idx - 1'b1);
                buf_wdata = reg_rdata;
            end
            S_COMMIT: begin
                reg_wr_en = !cs_n;
            end
            S_RESP: begin
                buf_raddr = OFS_W'(idx - 1'b1);
                if (idx == '0)                    tx_byte = result;
                else if (idx == rsp_total - 1'b1) tx_byte = rsp_crc;
                else                              tx_byte = buf_rdata;
            end
            S_PAYLOAD: begin
                buf_we = rx_valid && (idx != cur_len);
            end
            S_HDR, S_DRAIN, S_PAYCHK, S_HOLD: begin
                tx_byte = FILL_BYTE;
            end
            default: begin
                tx_byte = FILL_BYTE;
            end
        endcase
    end
endmodule

// File: rtl/spi_req_engine_chk.sv
module spi_req_engine_chk
    import spi_eng_pkg::*;
#(
    parameter int OFS_W = 4,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic [7:0]       tx_byte,
    input logic             reg_wr_en,
    input logic             reg_rd_en,
    input logic [OFS_W-1:0] reg_offset,
    input eng_state_e       state,
    input logic [IDX_W-1:0] idx,
    input logic [IDX_W-1:0] cur_len,
    input logic [IDX_W-1:0] rsp_total,
    input logic [7:0]       result
);
    function automatic logic [7:0] pair_of(input logic [7:0] code);
        unique case (code)
            8'hA0:   return 8'h69;
            8'hA1:   return 8'h6E;
            8'hA2:   return 8'h67;
            8'hA3:   return 8'h60;
            default: return 8'h75;
        endcase
    endfunction

    p_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HDR || state == S_PAYLOAD || state == S_HOLD || state == S_FETCH)
            |-> tx_byte == 8'hFF);

    p_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RESP && idx == '0)
            |-> (tx_byte >= 8'hA0 && tx_byte <= 8'hA4));

    p_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RESP && rsp_total == IDX_W'(2) && idx == IDX_W'(1))
            |-> tx_byte == pair_of(result));

    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (state == S_HDR && !reg_wr_en && !reg_rd_en));

    p_wr_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> IDX_W'(reg_offset) < cur_len);

    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr_en, reg_rd_en}));

    p_rd_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |-> (cur_len != '0 && IDX_W'(reg_offset) < cur_len));
endmodule

bind spi_req_engine spi_req_engine_chk #(.OFS_W(OFS_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .tx_byte    (tx_byte),
    .reg_wr_en  (reg_wr_en),
    .reg_rd_en  (reg_rd_en),
    .reg_offset (reg_offset),
    .state      (state),
    .idx        (idx),
    .cur_len    (cur_len),
    .rsp_total  (rsp_total),
    .result     (result)
);

// File: tb/test_spi_req_engine.sv
`timescale 1ns/1ps
module test_spi_req_engine;
    localparam int MAXP  = 16;
    localparam int OFS_W = $clog2(MAXP);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cs_n = 1'b1;
    logic             rx_valid = 1'b0;
    logic [7:0]       rx_byte = 8'h00;
    logic             tx_load = 1'b0;
    logic [7:0]       tx_byte;
    logic [7:0]       reg_addr;
    logic [OFS_W-1:0] reg_offset;
    logic             reg_rd_en;
    logic [7:0]       reg_rdata;
    logic             reg_wr_en;
    logic [7:0]       reg_wdata;
    logic             reg_ok;
    logic [7:0]       reg_max_len;

    int checks = 0;
    int failures = 0;
    int wr_count = 0;
    int rd_count = 0;
    logic [7:0] regmem [0:7][0:MAXP-1];
    logic [7:0] rsp [0:19];

    always #2 clk = ~clk;

    spi_req_engine #(.MAX_PAYLOAD(MAXP)) i_spi_req_engine (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_load(tx_load), .tx_byte(tx_byte),
        .reg_addr(reg_addr), .reg_offset(reg_offset), .reg_rd_en(reg_rd_en),
        .reg_rdata(reg_rdata), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_ok(reg_ok), .reg_max_len(reg_max_len)
    );

    // Register-file model: registers 0..7; reg 3 takes up to 4 bytes, reg 0 up to 255, others 12
    assign reg_ok      = (reg_addr < 8'd8);
    assign reg_max_len = (reg_addr == 8'd3) ? 8'd4 : ((reg_addr == 8'd0) ? 8'd255 : 8'd12);

    always @(posedge clk) begin
        if (reg_rd_en) begin
            reg_rdata <= regmem[reg_addr[2:0]][reg_offset];
            rd_count  <= rd_count + 1;
        end
        if (reg_wr_en) begin
            regmem[reg_addr[2:0]][reg_offset] <= reg_wdata;
            wr_count <= wr_count + 1;
        end
    end

    function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] x;
        x = c ^ d;
        for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
        return x;
    endfunction

    function automatic logic [7:0] crc3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        return crc8(crc8(crc8(8'h00, a), b), c);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] mosi, output logic [7:0] miso);
        @(negedge clk);
        miso = tx_byte;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        repeat (2) @(negedge clk);
        rx_byte  = mosi;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic cs_low();
        @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic cs_high();
        @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // Send four header bytes; all replies during the header must be fill bytes (R4)
    task automatic send_req(input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] b2, input logic [7:0] b3);
        logic [7:0] m;
        logic       all_ff;
        all_ff = 1'b1;
        xfer(b0, m); if (m !== 8'hFF) all_ff = 1'b0;
        xfer(b1, m); if (m !== 8'hFF) all_ff = 1'b0;
        xfer(b2, m); if (m !== 8'hFF) all_ff = 1'b0;
        xfer(b3, m); if (m !== 8'hFF) all_ff = 1'b0;
        chk("R4 fill during request", {31'd0, all_ff}, 32'd1);
    endtask

    task automatic get_rsp(input int n);
        logic [7:0] m;
        int tries;
        tries = 0;
        m = 8'hFF;
        while (m === 8'hFF && tries < 60) begin
            xfer(8'h00, m);
            tries++;
        end
        rsp[0] = m;
        for (int i = 1; i < n; i++) begin
            xfer(8'h00, m);
            rsp[i] = m;
        end
    endtask

    task automatic expect_short(input string req, input logic [7:0] code, input logic [7:0] pair);
        get_rsp(2);
        chk({req, " result"}, {24'd0, rsp[0]}, {24'd0, code});
        chk({"R5 pair ", req}, {24'd0, rsp[1]}, {24'd0, pair});
    endtask

    task automatic t_reset();
        chk("R4 reset tx_byte", {24'd0, tx_byte}, 32'hFF);
        chk("R11 reset strobes", {30'd0, reg_wr_en, reg_rd_en}, 32'd0);
    endtask

    task automatic t_short_write();
        cs_low();
        send_req(8'hC2, 8'd5, 8'h5A, crc3(8'hC2, 8'd5, 8'h5A));
        expect_short("R2 R1 short write", 8'hA0, 8'h69);
        cs_high();
        chk("R10 short write committed", {24'd0, regmem[5][0]}, 32'h5A);
    endtask

    task automatic t_long_write();
        logic [7:0] m;
        logic [7:0] pc;
        int w0;
        w0 = wr_count;
        cs_low();
        send_req(8'hC3, 8'd6, 8'd3, crc3(8'hC3, 8'd6, 8'd3));
        expect_short("R8 long start", 8'hA0, 8'h69);
        pc = crc3(8'h11, 8'h22, 8'h33);
        xfer(8'h11, m); xfer(8'h22, m); xfer(8'h33, m); xfer(pc, m);
        expect_short("R8 long payload", 8'hA0, 8'h69);
        cs_high();
        chk("R11 long write bytes", {8'd0, regmem[6][0], regmem[6][1], regmem[6][2]}, 32'h00112233);
        chk("R11 long write strobes", wr_count - w0, 32'd3);
    endtask

    task automatic t_read();
        logic [7:0] c;
        cs_low();
        send_req(8'hC1, 8'd6, 8'd3, crc3(8'hC1, 8'd6, 8'd3));
        get_rsp(5);
        cs_high();
        c = crc8(crc8(crc8(crc8(8'h00, 8'hA0), 8'h11), 8'h22), 8'h33);
        chk("R6 read result", {24'd0, rsp[0]}, 32'hA0);
        chk("R6 R11 read data", {8'd0, rsp[1], rsp[2], rsp[3]}, 32'h00112233);
        chk("R6 read crc", {24'd0, rsp[4]}, {24'd0, c});
    endtask

    task automatic t_errors();
        int w0;
        int r0;
        w0 = wr_count;
        cs_low();
        send_req(8'hC2, 8'd5, 8'h11, crc3(8'hC2, 8'd5, 8'h11) ^ 8'h01);
        expect_short("R10 bad crc", 8'hA1, 8'h6E);
        cs_high();
        chk("R10 no write on bad crc", {24'd0, regmem[5][0]}, 32'h5A);
        chk("R10 no strobe on bad crc", wr_count - w0, 32'd0);

        cs_low();
        send_req(8'h55, 8'd1, 8'd1, crc3(8'h55, 8'd1, 8'd1));
        expect_short("R2 bad type", 8'hA2, 8'h67);
        cs_high();

        cs_low();
        send_req(8'h55, 8'd1, 8'd1, 8'h00);
        expect_short("R3 crc beats type", 8'hA1, 8'h6E);
        cs_high();

        cs_low();
        send_req(8'hC0, 8'd20, 8'd1, crc3(8'hC0, 8'd20, 8'd1));
        expect_short("R3 bad register", 8'hA3, 8'h60);
        cs_high();

        r0 = rd_count;
        cs_low();
        send_req(8'hC0, 8'd6, 8'd0, crc3(8'hC0, 8'd6, 8'd0));
        expect_short("R7 zero length", 8'hA4, 8'h75);
        cs_high();
        cs_low();
        send_req(8'hC0, 8'd3, 8'd5, crc3(8'hC0, 8'd3, 8'd5));
        expect_short("R7 over reg limit", 8'hA4, 8'h75);
        cs_high();
        cs_low();
        send_req(8'hC1, 8'd0, 8'd17, crc3(8'hC1, 8'd0, 8'd17));
        expect_short("R7 over buffer", 8'hA4, 8'h75);
        cs_high();
        chk("R7 no reads on bad length", rd_count - r0, 32'd0);
    endtask

    task automatic t_long_bad_crc();
        logic [7:0] m;
        int w0;
        w0 = wr_count;
        cs_low();
        send_req(8'hC3, 8'd6, 8'd2, crc3(8'hC3, 8'd6, 8'd2));
        expect_short("R8 long start 2", 8'hA0, 8'h69);
        xfer(8'h99, m); xfer(8'h88, m); xfer(8'h00, m);
        expect_short("R10 payload bad crc", 8'hA1, 8'h6E);
        cs_high();
        chk("R10 payload not committed", {16'd0, regmem[6][0], regmem[6][1]}, 32'h1122);
        chk("R10 payload no strobes", wr_count - w0, 32'd0);
    endtask

    task automatic t_long_reject();
        logic [7:0] m;
        logic all_ff;
        int w0;
        w0 = wr_count;
        all_ff = 1'b1;
        cs_low();
        send_req(8'hC3, 8'd3, 8'd9, crc3(8'hC3, 8'd3, 8'd9));
        expect_short("R8 rejected start", 8'hA4, 8'h75);
        for (int i = 0; i < 6; i++) begin
            xfer(8'h40 + 8'(i), m);
            if (m !== 8'hFF) all_ff = 1'b0;
        end
        cs_high();
        chk("R8 R4 ignored after reject", {31'd0, all_ff}, 32'd1);
        chk("R8 no writes after reject", wr_count - w0, 32'd0);
    endtask

    task automatic t_abort();
        logic [7:0] m;
        int w0;
        cs_low();
        xfer(8'hC2, m); xfer(8'd5, m);
        cs_high();
        cs_low();
        send_req(8'hC2, 8'd5, 8'h77, crc3(8'hC2, 8'd5, 8'h77));
        expect_short("R9 fresh frame after abort", 8'hA0, 8'h69);
        cs_high();
        chk("R9 write after abort", {24'd0, regmem[5][0]}, 32'h77);

        w0 = wr_count;
        cs_low();
        send_req(8'hC3, 8'd6, 8'd2, crc3(8'hC3, 8'd6, 8'd2));
        expect_short("R9 long start", 8'hA0, 8'h69);
        xfer(8'hEE, m);
        cs_high();
        chk("R9 aborted payload not committed", {16'd0, regmem[6][0], regmem[6][1]}, 32'h1122);
        chk("R9 aborted payload no strobes", wr_count - w0, 32'd0);
        chk("R9 R4 idle after abort", {24'd0, tx_byte}, 32'hFF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short_write();
        t_long_write();
        t_read();
        t_errors();
        t_long_bad_crc();
        t_long_reject();
        t_abort();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule